// File: doc/BRIEF.md
# SDRAM Burst Termination Sequencer

This block is the burst engine on the device side of a synchronous DRAM data port. When a read or write column command is registered, it walks the column address through a burst of `BL` beats and raises an array read or write strobe for each beat. For reads, it delays a data-valid flag by the selected CAS latency, which is 2 or 3. The memory array, row activation, refresh and bank bookkeeping are outside the block.

A burst can end early in four ways, and each ends it differently. A burst stop ends the column walk and leaves the row open. Read beats already fetched still leave the pins, and write beats that had not yet arrived are discarded. A precharge also cuts the walk short, but it must respect write recovery. After a read, a precharge issued on the edge right after the final column access still lets every beat out. A new read or write restarts the walk at its own column. A new write also removes any read data that is still in flight.

Commands arrive on a valid/ready handshake. A command is taken on a rising edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` drops only for a precharge that would break write recovery. The controller must hold such a precharge, or withdraw it. Reads, writes and burst stops are never stalled. The outgoing strobes and the data-valid flag have no back-pressure, because a DRAM cannot pause a burst. `cas_sel` must stay unchanged while read data is outstanding.

Top module: `sdr_burst_seq`

## Requirements
- R1: A read taken at edge n sets `arr_rd` high in the BL cycles that follow edges n to n+BL-1. Beat i carries `col_addr` equal to the command column with its low log2(BL) bits replaced by (low bits + i) mod BL.
- R2: A write taken at edge n sets `arr_wr` high in the cycles that follow edges n to n+BL-1. The strobe after edge n+i writes the DQ beat presented at edge n+i, so the command edge carries beat 0. `col_addr` follows the same wrapping order as in R1.
- R3: `rd_valid` is high for one cycle per read beat, so that beat i is sampled at edge n+CL+i. `cas_sel`=0 selects CL 2 and `cas_sel`=1 selects CL 3. The value is captured with the read command.
- R4: A burst stop taken at edge s during a write ends `arr_wr` from the cycle after edge s. Beats presented at edges before s are written, and the beat at s and all later beats are not.
- R5: A burst stop taken at edge s during a read ends `arr_rd` from the cycle after edge s. Beats fetched before s still raise `rd_valid`, and no data is sampled from edge s+CL onward.
- R6: A precharge taken at edge p during a read truncates the read the same way as R5. A precharge at edge n+BL, after a read at n, delivers all BL beats at either CL. Every accepted precharge raises `pre_go` for the one cycle after its edge.
- R7: With `cmd_op`=precharge (2'b10), `cmd_ready` is low unless the coming edge is at least WR_CYC edges after the edge of the last written beat. A precharge that is refused produces no `pre_go` and changes no output.
- R8: A read or write taken while a burst runs restarts the beat count at its own column and direction from the cycle after its edge.
- R9: A write taken at edge n clears every pending `rd_valid` from the cycle after edge n onward.
- R10: A read taken during a read leaves the earlier burst's already-fetched beats on `rd_valid`, followed directly by the new beats.
- R11: A burst stop or precharge taken with no burst running raises no strobe and no `rd_valid`.
- R12: During and right after reset, `arr_rd`, `arr_wr`, `rd_valid` and `pre_go` are low and `cmd_ready` is high.
- R13: `cmd_ready` is high whenever `cmd_op` is read (2'b00), write (2'b01) or burst stop (2'b11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 00 read, 01 write, 10 precharge, 11 burst stop |
| cmd_col | input | COL_W | Start column for read or write |
| cas_sel | input | 1 | 0: CAS latency 2, 1: CAS latency 3 |
| cmd_ready | output | 1 | Command can be taken this edge |
| col_addr | output | COL_W | Column of the current beat |
| arr_rd | output | 1 | Array read strobe for the current beat |
| arr_wr | output | 1 | Array write strobe for the current beat |
| rd_valid | output | 1 | Read data is on the pins for the next edge |
| pre_go | output | 1 | One-cycle pulse after an accepted precharge |

## Verification
The strobes and `col_addr` for a command taken at edge n are due in the cycle after edge n, one register away. `rd_valid` trails the strobe by CL-1 further cycles, and `pre_go` is due one cycle after its edge. `cmd_ready` is combinational and is checked one time step after the inputs are driven. The bench keeps a schedule of expected values, indexed by edge number. Each command writes future entries into it and each termination cancels them. Every output is then compared at the falling edge inside the cycle the schedule names, so each check lands exactly on the latency that the requirement gives.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  typedef enum logic [1:0] {
    OP_RD   = 2'd0,
    OP_WR   = 2'd1,
    OP_PRE  = 2'd2,
    OP_STOP = 2'd3
  } col_op_e;
endpackage

// File: rtl/sbt_burst_ctr.sv
module sbt_burst_ctr
  import sbt_pkg::*;
#(
  parameter int COL_W = 9,
  parameter int BL    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  col_op_e          op,
  input  logic [COL_W-1:0] col,
  output logic [COL_W-1:0] col_addr,
  output logic             acc_rd,
  output logic             acc_wr
);
  localparam int BLW = $clog2(BL);
  localparam logic [BLW-1:0] LAST = BLW'(BL - 1);

  logic             active;
  logic             is_wr;
  logic [COL_W-1:0] base;
  logic [BLW-1:0]   idx;
  logic             start;

  assign start = fire && (op == OP_RD || op == OP_WR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      is_wr  <= 1'b0;
      base   <= '0;
      idx    <= '0;
    end else if (start) begin
      active <= 1'b1;
      is_wr  <= (op == OP_WR);
      base   <= col;
      idx    <= '0;
    end else if (fire) begin
      active <= 1'b0;
    end else if (active) begin
      if (idx == LAST) active <= 1'b0;
      idx <= idx + 1'b1;
    end
  end

  // sequential order, wrapping inside the BL-aligned block
  assign col_addr = {base[COL_W-1:BLW], base[BLW-1:0] + idx};
  assign acc_rd   = active && !is_wr;
  assign acc_wr   = active && is_wr;

  // R1
  wrap_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !fire && idx != LAST) |=>
      ((acc_rd || acc_wr) && col_addr[COL_W-1:BLW] == $past(col_addr[COL_W-1:BLW])));

  // R4
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_STOP) |=> (!acc_rd && !acc_wr));
endmodule

// File: rtl/sbt_rd_pipe.sv
module sbt_rd_pipe #(
  parameter int MAX_CL = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_in,
  input  logic flush,
  input  logic cl_load,
  input  logic cl3_in,
  output logic rd_valid
);
  localparam int DEPTH = MAX_CL - 1;

  logic [DEPTH-1:0] p;
  logic             cl3_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p     <= '0;
      cl3_q <= 1'b0;
    end else begin
      if (cl_load) cl3_q <= cl3_in;
      if (flush) p <= '0;
      else       p <= {p[DEPTH-2:0], rd_in};
    end
  end

  assign rd_valid = cl3_q ? p[DEPTH-1] : p[0];

  // R3
  cl2_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cl3_q && $past(rd_in) && !$past(flush)) |-> rd_valid);

  // R3
  cl3_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cl3_q && $past(rd_in, 2) && !$past(flush) && !$past(flush, 2)) |-> rd_valid);
endmodule

// File: rtl/sbt_wr_recov.sv
module sbt_wr_recov #(
  parameter int WR_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_beat,
  output logic pre_ok
);
  localparam int CW = $clog2(WR_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (wr_beat)     cnt <= CW'(WR_CYC - 2);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign pre_ok = (cnt == '0) && !wr_beat;
endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
  import sbt_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BL     = 4,
  parameter int WR_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             cas_sel,
  output logic             cmd_ready,
  output logic [COL_W-1:0] col_addr,
  output logic             arr_rd,
  output logic             arr_wr,
  output logic             rd_valid,
  output logic             pre_go
);
  col_op_e op;
  logic    fire;
  logic    pre_ok;

  assign op        = col_op_e'(cmd_op);
  assign cmd_ready = (op != OP_PRE) || pre_ok;
  assign fire      = cmd_valid && cmd_ready;

  sbt_burst_ctr #(.COL_W(COL_W), .BL(BL)) u_ctr (
    .clk(clk), .rst_n(rst_n), .fire(fire), .op(op), .col(cmd_col),
    .col_addr(col_addr), .acc_rd(arr_rd), .acc_wr(arr_wr)
  );

  sbt_rd_pipe #(.MAX_CL(3)) u_rdp (
    .clk(clk), .rst_n(rst_n), .rd_in(arr_rd),
    .flush(fire && op == OP_WR),
    .cl_load(fire && op == OP_RD), .cl3_in(cas_sel),
    .rd_valid(rd_valid)
  );

  sbt_wr_recov #(.WR_CYC(WR_CYC)) u_rec (
    .clk(clk), .rst_n(rst_n), .wr_beat(arr_wr), .pre_ok(pre_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pre_go <= 1'b0;
    else        pre_go <= fire && (op == OP_PRE);
  end

  // R7
  pre_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_PRE) |-> !arr_wr);

  // R6
  pre_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_PRE) |=> pre_go);

  // R9
  wr_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_WR) |=> !rd_valid);
endmodule

// File: tb/sdr_burst_seq_tb.sv
`timescale 1ns/1ps
module sdr_burst_seq_tb;
  localparam int COL_W  = 9;
  localparam int BL     = 4;
  localparam int WR_CYC = 3;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, PRE = 2'd2, STP = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = RD;
  logic [COL_W-1:0] cmd_col = '0;
  logic cas_sel = 1'b0;
  logic cmd_ready, arr_rd, arr_wr, rd_valid, pre_go;
  logic [COL_W-1:0] col_addr;

  always #10 clk = ~clk;

  sdr_burst_seq #(.COL_W(COL_W), .BL(BL), .WR_CYC(WR_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_col(cmd_col), .cas_sel(cas_sel), .cmd_ready(cmd_ready),
    .col_addr(col_addr), .arr_rd(arr_rd), .arr_wr(arr_wr),
    .rd_valid(rd_valid), .pre_go(pre_go)
  );

  int nvec = 0, nbad = 0, t = 0, last_wr = -100, cl_cur = 2;
  bit done = 0;
  bit e_rd[64], e_wr[64], e_rdv[64], e_pre[64];
  int e_col[64];

  function automatic int sl(int j); return j & 63; endfunction

  function automatic int wrap_col(int c, int i);
    return ((c & ~(BL - 1)) | ((c + i) & (BL - 1))) & ((1 << COL_W) - 1);
  endfunction

  function automatic bit want_ready(logic [1:0] op);
    if (op != PRE) return 1'b1;
    return (t + 1 - last_wr) >= WR_CYC;
  endfunction

  task automatic chk(string tag, int act, int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h at edge %0d", tag, act, exp, t);
    end
  endtask

  function automatic void cancel_from(int n);
    for (int j = n; j < n + BL + 4; j++) begin
      if (e_rd[sl(j)]) e_rdv[sl(j + cl_cur - 1)] = 1'b0;
      e_rd[sl(j)] = 1'b0;
      e_wr[sl(j)] = 1'b0;
    end
  endfunction

  function automatic void apply(logic [1:0] op, int c, int n);
    cancel_from(n);
    case (op)
      RD: for (int i = 0; i < BL; i++) begin
            e_rd[sl(n + i)] = 1'b1;
            e_col[sl(n + i)] = wrap_col(c, i);
            e_rdv[sl(n + i + cl_cur - 1)] = 1'b1;
          end
      WR: begin
            for (int j = n; j <= n + BL; j++) e_rdv[sl(j)] = 1'b0;
            for (int i = 0; i < BL; i++) begin
              e_wr[sl(n + i)] = 1'b1;
              e_col[sl(n + i)] = wrap_col(c, i);
            end
          end
      PRE: e_pre[sl(n)] = 1'b1;
      default: ;
    endcase
  endfunction

  task automatic check_outputs();
    int s = sl(t);
    chk("R1 arr_rd", arr_rd, e_rd[s]);
    chk("R2 arr_wr", arr_wr, e_wr[s]);
    chk("R3 rd_valid", rd_valid, e_rdv[s]);
    chk("R6 pre_go", pre_go, e_pre[s]);
    if (e_rd[s] || e_wr[s]) chk("R1 col_addr", col_addr, e_col[s]);
    if (e_wr[s]) last_wr = t;
    e_rd[s] = 0; e_wr[s] = 0; e_rdv[s] = 0; e_pre[s] = 0;
  endtask

  task automatic step(bit v, logic [1:0] op, int c);
    bit r;
    check_outputs();
    cmd_valid = v; cmd_op = op; cmd_col = COL_W'(c);
    #1;
    r = want_ready(op);
    if (v) chk(op == PRE ? "R7 cmd_ready" : "R13 cmd_ready", cmd_ready, r);
    @(posedge clk);
    t++;
    if (v && r) apply(op, c, t);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(1'b0, RD, 0);
  endtask

  task automatic set_cl(bit c3);
    cas_sel = c3; cl_cur = c3 ? 3 : 2;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nbad++;
      $display("FAIL R12 watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R12: outputs while in reset, precharge offered
    cmd_op = PRE; #1;
    chk("R12 reset arr_rd", arr_rd, 0);
    chk("R12 reset arr_wr", arr_wr, 0);
    chk("R12 reset rd_valid", rd_valid, 0);
    chk("R12 reset pre_go", pre_go, 0);
    chk("R12 reset cmd_ready", cmd_ready, 1);
    cmd_op = RD;
    @(negedge clk); rst_n = 1'b1; t = 0;
    set_cl(0);
    // R1 R3: CL2 read with wrap from column 6
    step(1, RD, 9'h006); idle(8);
    // R6: CL2 precharge at edge n+BL keeps every beat
    step(1, RD, 9'h010); idle(3); step(1, PRE, 0); idle(6);
    set_cl(1);
    // R6: CL3 precharge at edge n+BL keeps every beat
    step(1, RD, 9'h021); idle(3); step(1, PRE, 0); idle(6);
    // R5: burst stop during a read
    step(1, RD, 9'h033); idle(1); step(1, STP, 0); idle(6);
    // R10: read interrupting a read
    step(1, RD, 9'h040); idle(1); step(1, RD, 9'h055); idle(8);
    // R9: write interrupting a read flushes data in flight
    step(1, RD, 9'h060); idle(1); step(1, WR, 9'h073); idle(6);
    // R4 R7: stop during write, then precharge held off by recovery
    step(1, WR, 9'h081); idle(1); step(1, STP, 0);
    for (int k = 0; k < 5; k++) step(1, PRE, 0);
    idle(4);
    // R8: write restarted by a new write
    step(1, WR, 9'h090); idle(1); step(1, WR, 9'h0A3); idle(6);
    // R11: stop and precharge with no burst running
    step(1, STP, 0); step(1, PRE, 0); idle(3);
    // random traffic, one block per CAS latency
    for (int blk = 0; blk < 2; blk++) begin
      idle(8);
      set_cl(blk[0]);
      for (int k = 0; k < 400; k++)
        step(($urandom % 4) != 0, 2'($urandom % 4), int'($urandom % 512));
    end
    idle(8);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule